// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. Its clock stands for the oscillator signal. A fixed divide-by-8 stage sits in front of a dual-modulus stage that divides by 32 or by 33. A 10-bit main count M and a 5-bit swallow count S steer that stage. The 33 modulus is used for the first S outputs of every division cycle, and the 32 modulus is used for the remaining M−S outputs. The total ratio from the clock to the feedback pulse is therefore 8·(32M+S).

The dual-modulus stage is modelled inside the block, so the divider can be used and checked without any external prescaler model. The modulus-control line is also brought out as a port. The feedback output is a one-clock pulse at the end of each complete division and goes to the phase detector. New M and S values are taken only at that boundary, so no period is ever cut short or stretched by a reprogramming.

Top module: `pswl_divider`

## Requirements
- R1: After reset, fb_pulse_o and mod_hi_o are low. Until the first boundary the divider runs with M=32 and S=0, so the first feedback pulse follows 8192 clocks after reset is released.
- R2: For M in 32..1023 and S in 0..31, the spacing between consecutive feedback pulses is 8·(32M+S) clocks.
- R3: mod_hi_o is high (modulus 33) from the start of a division cycle for exactly S dual-modulus outputs, which is 264·S clocks. It is low for the rest of the cycle, and it changes only at a dual-modulus output boundary.
- R4: With S=0, mod_hi_o stays low for the whole cycle.
- R5: A main count below 32 is used as 32.
- R6: main_cnt_i and swal_cnt_i are sampled only on the clock edge that ends a division cycle. A change in the middle of a cycle does not alter the length of the cycle in progress.
- R7: Each feedback pulse is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock; the divided signal |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_cnt_i | input | 10 | Main count M, unsigned |
| swal_cnt_i | input | 5 | Swallow count S, unsigned |
| mod_hi_o | output | 1 | Modulus control: 1 selects 33, 0 selects 32 |
| fb_pulse_o | output | 1 | One-clock pulse per complete division |

## Verification
The divider is driven with several (M,S) pairs:
- S=0 at the minimum M.
- S=31 at the minimum M.
- S=1, where a single swallow is the only difference from plain 32·M.
- A mid-range S at a larger M.

For each pair the bench measures both the pulse spacing and the number of clocks spent at modulus 33. This separates an error in the swallow count from an error in the main count.

Further tests cover the remaining corner cases:
- A main count below the minimum checks the clamp.
- A reprogramming in the middle of a cycle shows whether the running period is disturbed.
- The first period after reset checks the default ratio.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
    localparam int PRE_DIV_DEF = 8;    // fixed front stage ratio
    localparam int DM_LOW_DEF  = 32;   // low modulus of dual stage
    localparam int MAIN_W_DEF  = 10;
    localparam int SWAL_W_DEF  = 5;
    localparam int M_MIN_DEF   = 32;   // smallest usable main count
endpackage

// File: rtl/pswl_dualmod.sv
module pswl_dualmod #(
    parameter int PRE_DIV = pswl_pkg::PRE_DIV_DEF,
    parameter int DM_LOW  = pswl_pkg::DM_LOW_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_hi_i,
    output logic dm_tick_o
);
    localparam int DM_W  = $clog2(DM_LOW + 1);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic pre_tick;

    generate
        if (PRE_DIV > 1) begin : g_pre
            typedef struct packed {
                logic [PRE_W-1:0] cnt;
            } pre_t;
            pre_t pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (pre_q.cnt == PRE_W'(PRE_DIV - 1)) pre_d.cnt = '0;
                else                                  pre_d.cnt = pre_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign pre_tick = (pre_q.cnt == PRE_W'(PRE_DIV - 1));
        end else begin : g_nopre
            assign pre_tick = 1'b1;
        end
    endgenerate

    typedef struct packed {
        logic [DM_W-1:0] cnt;
    } dm_t;
    dm_t dm_d, dm_q;
    logic [DM_W-1:0] dm_last;

    always_comb begin
        dm_last = mod_hi_i ? DM_W'(DM_LOW) : DM_W'(DM_LOW - 1);
        dm_d    = dm_q;
        if (pre_tick) begin
            if (dm_q.cnt == dm_last) dm_d.cnt = '0;
            else                     dm_d.cnt = dm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dm_q <= '0;
        else        dm_q <= dm_d;
    end

    assign dm_tick_o = pre_tick && (dm_q.cnt == dm_last);

    AST_DM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dm_q.cnt <= DM_W'(DM_LOW)); // R2
    AST_MOD_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_tick_o |=> $stable(mod_hi_i)); // R3
endmodule

// File: rtl/pswl_counters.sv
module pswl_counters #(
    parameter int MAIN_W = pswl_pkg::MAIN_W_DEF,
    parameter int SWAL_W = pswl_pkg::SWAL_W_DEF,
    parameter int M_MIN  = pswl_pkg::M_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dm_tick_i,
    input  logic [MAIN_W-1:0] m_in_i,
    input  logic [SWAL_W-1:0] s_in_i,
    output logic              mod_hi_o,
    output logic              fb_o
);
    typedef struct packed {
        logic [MAIN_W-1:0] m_act;
        logic [SWAL_W-1:0] s_act;
        logic [MAIN_W-1:0] main_cnt;
        logic [SWAL_W-1:0] sw_cnt;
        logic              sw_on;
        logic              fb;
    } cnt_t;
    cnt_t st_d, st_q;
    logic cycle_end;

    always_comb begin
        st_d      = st_q;
        st_d.fb   = 1'b0;
        cycle_end = dm_tick_i && (st_q.main_cnt == st_q.m_act - 1'b1);
        if (cycle_end) begin
            st_d.main_cnt = '0;
            st_d.sw_cnt   = '0;
            st_d.m_act    = (m_in_i < MAIN_W'(M_MIN)) ? MAIN_W'(M_MIN) : m_in_i;
            st_d.s_act    = s_in_i;
            st_d.sw_on    = (s_in_i != '0);
            st_d.fb       = 1'b1;
        end else if (dm_tick_i) begin
            st_d.main_cnt = st_q.main_cnt + 1'b1;
            if (st_q.sw_on) begin
                if (st_q.sw_cnt == st_q.s_act - 1'b1) begin
                    st_d.sw_on  = 1'b0;
                    st_d.sw_cnt = '0;
                end else begin
                    st_d.sw_cnt = st_q.sw_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.m_act    <= MAIN_W'(M_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_hi_o = st_q.sw_on;
    assign fb_o     = st_q.fb;

    AST_FB_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fb_o |=> !fb_o); // R7
    AST_M_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.m_act >= MAIN_W'(M_MIN)); // R5
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_tick_i |=> ($stable(st_q.m_act) && $stable(st_q.s_act))); // R6
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_o && st_q.s_act != '0) |-> mod_hi_o); // R3
    AST_S0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s_act == '0) |-> !mod_hi_o); // R4
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
    parameter int PRE_DIV = pswl_pkg::PRE_DIV_DEF,
    parameter int DM_LOW  = pswl_pkg::DM_LOW_DEF,
    parameter int MAIN_W  = pswl_pkg::MAIN_W_DEF,
    parameter int SWAL_W  = pswl_pkg::SWAL_W_DEF,
    parameter int M_MIN   = pswl_pkg::M_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_cnt_i,
    input  logic [SWAL_W-1:0] swal_cnt_i,
    output logic              mod_hi_o,
    output logic              fb_pulse_o
);
    logic dm_tick;
    logic mod_hi;

    pswl_dualmod #(.PRE_DIV(PRE_DIV), .DM_LOW(DM_LOW)) i_dm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_hi_i (mod_hi),
        .dm_tick_o(dm_tick)
    );

    pswl_counters #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .M_MIN(M_MIN)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .dm_tick_i(dm_tick),
        .m_in_i   (main_cnt_i),
        .s_in_i   (swal_cnt_i),
        .mod_hi_o (mod_hi),
        .fb_o     (fb_pulse_o)
    );

    assign mod_hi_o = mod_hi;

    AST_FB_NO_MOD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse_o |-> !$past(fb_pulse_o)); // R7
endmodule

// File: tb/test_pswl_divider.sv
module test_pswl_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] m_in = 10'd32;
    logic [4:0] s_in = 5'd0;
    logic       mod_hi, fb;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pswl_divider i_pswl_divider (
        .clk(clk), .rst_n(rst_n), .main_cnt_i(m_in), .swal_cnt_i(s_in),
        .mod_hi_o(mod_hi), .fb_pulse_o(fb)
    );

    typedef struct packed { int m; int s; int per; } vec_t;
    localparam vec_t VECS [5] = '{
        '{32, 0, 8192}, '{32, 31, 8440}, '{33, 1, 8456},
        '{34, 16, 8832}, '{35, 7, 9016}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        @(negedge clk);
        while (!fb) @(negedge clk);
    endtask

    // called at the negedge where fb is seen high; returns at next such negedge
    task automatic measure(output int per, output int hi);
        per = 0; hi = 0;
        do begin
            if (mod_hi) hi++;
            @(posedge clk);
            per++;
            @(negedge clk);
        end while (!fb);
    endtask

    initial begin
        int per, hi, n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 fb in reset", int'(fb), 0);
        chk("R1 mod_hi in reset", int'(mod_hi), 0);
        m_in = 10'd33; s_in = 5'd1;
        rst_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!fb && n < 20000);
        chk("R1 first period", n, 8192);
        @(negedge clk);
        chk("R7 pulse width", int'(fb), 0);

        // R2/R3/R4 vector table
        foreach (VECS[i]) begin
            m_in = 10'(VECS[i].m); s_in = 5'(VECS[i].s);
            wait_pulse();
            measure(per, hi);
            chk("R2 period", per, VECS[i].per);
            chk(VECS[i].s == 0 ? "R4 mod33 clocks" : "R3 mod33 clocks", hi, 264 * VECS[i].s);
        end

        // R5: clamp of a small main count
        m_in = 10'd7; s_in = 5'd9;
        wait_pulse();
        measure(per, hi);
        chk("R5 clamped period", per, 8264);
        chk("R5 clamped mod33 clocks", hi, 264 * 9);

        // R6: mid-cycle change leaves the running period alone
        m_in = 10'd33; s_in = 5'd1;
        wait_pulse();
        n = 0;
        repeat (500) begin @(posedge clk); n++; @(negedge clk); end
        m_in = 10'd32; s_in = 5'd31;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!fb);
        chk("R6 running period kept", n, 8456);
        measure(per, hi);
        chk("R6 new values at boundary", per, 8440);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule